// File: doc/BRIEF.md
# LPC Memory Target Cycle Engine

This block is the target side of a four-bit Low Pin Count bus for a memory device. It watches the framing strobe and the nibble bus, and it recognises single-byte memory read and memory write cycles that are addressed to it. It then drives the short-wait sync, ready sync, data and turnaround nibbles back onto the bus, with a separate output enable that stands in for the tri-state driver. Each accepted cycle becomes one request on a simple byte interface to the back end, which holds the array or register storage and the command logic.

A four-bit strap selects which device on a shared bus answers. The strap sense is inverted: a strap bit held low selects an address bit of one. Cycles that have a bad type nibble, wrong upper address bits or a different device number leave the engine quiet until the next start condition. A framing pulse in the middle of a cycle aborts that cycle and releases the bus at once. A write whose data has been fully received still reaches the back end even if the abort comes during its closing turnaround.

Top module: `lpcMemTarget`

## Requirements
- R1: A cycle begins only at a rising clock edge where `frameN` is low and `ladIn` is 4'h0. A framed nibble other than 4'h0 starts nothing and gets no response.
- R2: At the edge after the start, the cycle-type nibble is accepted only if bits 3:2 are 2'b01. Bit 1 selects write (1) or read (0), and bit 0 must be 0 for a read and is ignored for a write. Any other type nibble gives no response.
- R3: Eight address nibbles follow, most significant first. Address bits 31:23 must all be 1 or the cycle gets no response. Bit 22 goes out on `beArray` and bits 17:0 on `beAddr`.
- R4: Address bit 18+i must equal the inverse of `idStrap[i]` for i = 0..3. On any mismatch the block neither responds nor strobes the back end.
- R5: On an accepted read, `ladOe` stays low for the two host turnaround cycles. In the same cycle as the first of them, `beRd` pulses and `beRdata` is captured. The block then drives 4'h5 for WAIT_CYC cycles (default 2), 4'h0 once, the low data nibble, the high data nibble and 4'hF, and then releases the bus.
- R6: On an accepted write, the low data nibble is taken first and then the high nibble. `ladOe` stays low for two host turnaround cycles. The block then drives 4'h0 once and 4'hF once and releases the bus. The received byte is presented on `beWdata`.
- R7: `beWr` pulses for one cycle, in the cycle right after the edge that takes the high data nibble. A later abort does not cancel it. An abort at or before that edge means no write is issued.
- R8: Whenever `frameN` is low after the start cycle, `ladOe` is low in that same cycle and the current cycle is dropped. If the framed nibble is 4'h0, a new cycle starts from it.
- R9: While either `rstN` or `initN` is low, the engine is idle, `ladOe` is low and neither back-end strobe is asserted. Lowering `initN` in the middle of a cycle releases the bus at once.
- R10: `beRd` and `beWr` are never asserted together. Each pulse lasts one cycle, and there is exactly one pulse per accepted cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Interface reset, active low |
| initN | input | 1 | Processor reset, active low, combined with rstN |
| frameN | input | 1 | Cycle framing strobe, active low |
| ladIn | input | 4 | Nibble bus as seen at the input buffer |
| ladOut | output | 4 | Nibble driven by the target |
| ladOe | output | 1 | Output enable for the nibble driver |
| idStrap | input | 4 | Device-number strap, inverted sense |
| beAddr | output | BE_ADDR_W | Byte address to the back end |
| beArray | output | 1 | 1 selects array, 0 selects registers |
| beWdata | output | 8 | Write byte to the back end |
| beWr | output | 1 | One-cycle write strobe |
| beRd | output | 1 | One-cycle read strobe |
| beRdata | input | 8 | Read byte, sampled while beRd is high |

## Verification
The bound checker watches the things that must hold on every cycle. These are: the bus released in any cycle with `frameN` low, quiet outputs while either reset is low, strobes that are single and never overlapping, a quiet bus in the cycle after a read strobe, and a sync nibble as the first thing driven. Only the bench scenarios can show the exact nibble order and timing of read and write responses, the address, strap and type decoding, and the difference between an abort before and after the write commit point. They also show restart on a framed start nibble and recovery after a processor reset in the middle of a cycle.

// File: rtl/lpcTgtPkg.sv
`timescale 1ns/1ps
package lpcTgtPkg;
  localparam int NIB_W      = 4;
  localparam int ADDR_NIBS  = 8;
  localparam int ID_W       = 4;
  localparam int ID_LSB     = 18;
  localparam int ARRAY_BIT  = 22;
  localparam int UPPER_LSB  = 23;

  localparam logic [NIB_W-1:0] NIB_START = 4'h0;
  localparam logic [NIB_W-1:0] NIB_SWAIT = 4'h5;
  localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
  localparam logic [NIB_W-1:0] NIB_TURN  = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_WDAT, ST_HTAR,
    ST_WSYNC, ST_RSYNC, ST_RDAT, ST_ACK, ST_TTAR
  } tgtState_e;

  typedef enum logic [2:0] {
    OS_SWAIT, OS_READY, OS_DLO, OS_DHI, OS_TURN
  } outSel_e;

  typedef struct packed {
    logic    shiftAddr;
    logic    capLo;
    logic    capHi;
    logic    capRd;
    logic    drive;
    outSel_e outSel;
  } ctlStrobe_t;
endpackage

// File: rtl/lpcTgtCtrl.sv
`timescale 1ns/1ps
module lpcTgtCtrl
  import lpcTgtPkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rstAllN,
  input  logic             frameN,
  input  logic [NIB_W-1:0] ladIn,
  input  logic             typeOk,
  input  logic             typeWr,
  input  logic             addrOk,
  output ctlStrobe_t       strobe,
  output logic             beRd,
  output logic             beWr
);
  localparam int CNT_MAX = (WAIT_CYC > ADDR_NIBS) ? WAIT_CYC : ADDR_NIBS;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  tgtState_e        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             isWr, nextWr;

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      isWr  <= nextWr;
    end
  end

  always_comb begin
    nextState     = state;
    nextCnt       = cnt;
    nextWr        = isWr;
    strobe        = '0;
    strobe.outSel = OS_TURN;
    beRd          = 1'b0;
    beWr          = 1'b0;
    case (state)
      ST_IDLE: ;
      ST_CTYPE: begin
        nextCnt = '0;
        if (typeOk) begin
          nextState = ST_ADDR;
          nextWr    = typeWr;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_ADDR: begin
        strobe.shiftAddr = 1'b1;
        if (cnt == LAST_ADDR) begin
          nextCnt   = '0;
          nextState = isWr ? ST_WDAT : ST_HTAR;
        end else begin
          nextCnt = cnt + CNT_ONE;
        end
      end
      ST_WDAT: begin
        if (cnt == '0) begin
          if (!addrOk) begin
            nextState = ST_IDLE;
          end else begin
            strobe.capLo = 1'b1;
            nextCnt      = CNT_ONE;
          end
        end else begin
          strobe.capHi = 1'b1;
          nextCnt      = '0;
          nextState    = ST_HTAR;
        end
      end
      ST_HTAR: begin
        if (cnt == '0) begin
          if (!addrOk) begin
            nextState = ST_IDLE;
          end else begin
            beWr         = isWr;
            beRd         = !isWr;
            strobe.capRd = !isWr;
            nextCnt      = CNT_ONE;
          end
        end else begin
          nextCnt   = '0;
          nextState = isWr ? ST_ACK : ST_WSYNC;
        end
      end
      ST_WSYNC: begin
        strobe.drive  = 1'b1;
        strobe.outSel = OS_SWAIT;
        if (cnt == LAST_WAIT) begin
          nextCnt   = '0;
          nextState = ST_RSYNC;
        end else begin
          nextCnt = cnt + CNT_ONE;
        end
      end
      ST_RSYNC: begin
        strobe.drive  = 1'b1;
        strobe.outSel = OS_READY;
        nextCnt       = '0;
        nextState     = ST_RDAT;
      end
      ST_RDAT: begin
        strobe.drive = 1'b1;
        if (cnt == '0) begin
          strobe.outSel = OS_DLO;
          nextCnt       = CNT_ONE;
        end else begin
          strobe.outSel = OS_DHI;
          nextCnt       = '0;
          nextState     = ST_TTAR;
        end
      end
      ST_ACK: begin
        strobe.drive  = 1'b1;
        strobe.outSel = OS_READY;
        nextState     = ST_TTAR;
      end
      ST_TTAR: begin
        strobe.drive  = 1'b1;
        strobe.outSel = OS_TURN;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    // A framed nibble overrides everything: restart on a start nibble, else drop.
    if (!frameN) begin
      nextCnt          = '0;
      nextState        = (ladIn == NIB_START) ? ST_CTYPE : ST_IDLE;
      strobe.shiftAddr = 1'b0;
      strobe.capLo     = 1'b0;
      strobe.capHi     = 1'b0;
    end
  end
endmodule

// File: rtl/lpcTgtData.sv
`timescale 1ns/1ps
module lpcTgtData
  import lpcTgtPkg::*;
#(
  parameter int BE_ADDR_W = 18
) (
  input  logic                 clk,
  input  logic                 rstAllN,
  input  logic                 frameN,
  input  logic [NIB_W-1:0]     ladIn,
  input  logic [ID_W-1:0]      idStrap,
  input  ctlStrobe_t           strobe,
  output logic                 typeOk,
  output logic                 typeWr,
  output logic                 addrOk,
  output logic [BE_ADDR_W-1:0] beAddr,
  output logic                 beArray,
  output logic [7:0]           beWdata,
  input  logic [7:0]           beRdata,
  output logic [NIB_W-1:0]     ladOut,
  output logic                 ladOe
);
  localparam int ADDR_W = NIB_W * ADDR_NIBS;

  logic [ADDR_W-1:0] addrSh;
  logic [7:0]        wrByte;
  logic [7:0]        rdByte;
  logic [ID_W-1:0]   idHit;
  logic              upperOk;

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN) begin
      addrSh <= '0;
      wrByte <= '0;
      rdByte <= '0;
    end else begin
      if (strobe.shiftAddr) addrSh <= {addrSh[ADDR_W-NIB_W-1:0], ladIn};
      if (strobe.capLo)     wrByte[3:0] <= ladIn;
      if (strobe.capHi)     wrByte[7:4] <= ladIn;
      if (strobe.capRd)     rdByte <= beRdata;
    end
  end

  assign typeWr = ladIn[1];
  assign typeOk = (ladIn[3:2] == 2'b01) && (ladIn[1] || !ladIn[0]);

  // Strap low selects address bit one: a bit matches when it differs from its strap.
  for (genvar i = 0; i < ID_W; i++) begin : g_idCmp
    assign idHit[i] = addrSh[ID_LSB + i] ^ idStrap[i];
  end

  assign upperOk = &addrSh[ADDR_W-1:UPPER_LSB];
  assign addrOk  = upperOk && (&idHit);
  assign beAddr  = addrSh[BE_ADDR_W-1:0];
  assign beArray = addrSh[ARRAY_BIT];
  assign beWdata = wrByte;

  always_comb begin
    case (strobe.outSel)
      OS_SWAIT: ladOut = NIB_SWAIT;
      OS_READY: ladOut = NIB_READY;
      OS_DLO:   ladOut = rdByte[3:0];
      OS_DHI:   ladOut = rdByte[7:4];
      default:  ladOut = NIB_TURN;
    endcase
  end

  assign ladOe = strobe.drive && frameN && rstAllN;
endmodule

// File: rtl/lpcMemTarget.sv
`timescale 1ns/1ps
module lpcMemTarget
  import lpcTgtPkg::*;
#(
  parameter int BE_ADDR_W = 18,
  parameter int WAIT_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 initN,
  input  logic                 frameN,
  input  logic [3:0]           ladIn,
  output logic [3:0]           ladOut,
  output logic                 ladOe,
  input  logic [3:0]           idStrap,
  output logic [BE_ADDR_W-1:0] beAddr,
  output logic                 beArray,
  output logic [7:0]           beWdata,
  output logic                 beWr,
  output logic                 beRd,
  input  logic [7:0]           beRdata
);
  logic       rstAllN;
  ctlStrobe_t strobe;
  logic       typeOk, typeWr, addrOk;

  assign rstAllN = rstN & initN;

  lpcTgtCtrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rstAllN(rstAllN), .frameN(frameN), .ladIn(ladIn),
    .typeOk(typeOk), .typeWr(typeWr), .addrOk(addrOk),
    .strobe(strobe), .beRd(beRd), .beWr(beWr)
  );

  lpcTgtData #(.BE_ADDR_W(BE_ADDR_W)) u_data (
    .clk(clk), .rstAllN(rstAllN), .frameN(frameN), .ladIn(ladIn),
    .idStrap(idStrap), .strobe(strobe),
    .typeOk(typeOk), .typeWr(typeWr), .addrOk(addrOk),
    .beAddr(beAddr), .beArray(beArray), .beWdata(beWdata),
    .beRdata(beRdata), .ladOut(ladOut), .ladOe(ladOe)
  );
endmodule

// File: rtl/lpcMemTargetChk.sv
`timescale 1ns/1ps
module lpcMemTargetChk (
  input logic       clk,
  input logic       rstN,
  input logic       initN,
  input logic       frameN,
  input logic       ladOe,
  input logic [3:0] ladOut,
  input logic       beRd,
  input logic       beWr
);
  logic rstAllN;
  assign rstAllN = rstN && initN;

  p_release_on_frame_r8: assert property (@(posedge clk) disable iff (!rstAllN)
    !frameN |-> !ladOe);

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstAllN |-> (!ladOe && !beRd && !beWr));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstAllN)
    !(beRd && beWr));

  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rstAllN)
    beWr |=> !beWr);

  p_rd_single_r10: assert property (@(posedge clk) disable iff (!rstAllN)
    beRd |=> !beRd);

  p_host_turn_quiet_r5: assert property (@(posedge clk) disable iff (!rstAllN)
    beRd |=> !ladOe);

  p_first_drive_sync_r5: assert property (@(posedge clk) disable iff (!rstAllN)
    $rose(ladOe) |-> (ladOut == 4'h5 || ladOut == 4'h0));
endmodule

bind lpcMemTarget lpcMemTargetChk u_chk (
  .clk(clk), .rstN(rstN), .initN(initN), .frameN(frameN),
  .ladOe(ladOe), .ladOut(ladOut), .beRd(beRd), .beWr(beWr)
);

// File: tb/lpcMemTarget_tb.sv
`timescale 1ns/1ps
module lpcMemTarget_tb;
  logic        clk = 1'b0;
  logic        rstN, initN, frameN;
  logic [3:0]  ladIn, idStrap;
  logic [3:0]  ladOut;
  logic        ladOe, beArray, beWr, beRd;
  logic [17:0] beAddr;
  logic [7:0]  beWdata, beRdata;

  int total = 0, bad = 0, wrCnt = 0, rdCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lpcMemTarget u_dut (
    .clk(clk), .rstN(rstN), .initN(initN), .frameN(frameN), .ladIn(ladIn),
    .ladOut(ladOut), .ladOe(ladOe), .idStrap(idStrap), .beAddr(beAddr),
    .beArray(beArray), .beWdata(beWdata), .beWr(beWr), .beRd(beRd),
    .beRdata(beRdata)
  );

  // Back-end model: read byte derived from the presented address.
  assign beRdata = beAddr[7:0] ^ {beArray, 7'h2B};

  always @(negedge clk) begin
    if (beWr) wrCnt++;
    if (beRd) rdCnt++;
  end

  // {respond, cycle type, address, write byte}
  localparam logic [44:0] VEC [0:10] = '{
    {1'b1, 4'h4, 32'hFFE92345, 8'h00},
    {1'b1, 4'h6, 32'hFFE80ABC, 8'h3C},
    {1'b1, 4'h4, 32'hFFA8001F, 8'h00},
    {1'b1, 4'h7, 32'hFFA87F00, 8'hA5},
    {1'b0, 4'h4, 32'hFFE43000, 8'h00},
    {1'b0, 4'h6, 32'h7FE80000, 8'h11},
    {1'b1, 4'h6, 32'hFFEBFFFF, 8'hFF},
    {1'b0, 4'h5, 32'hFFE80000, 8'h00},
    {1'b0, 4'hC, 32'hFFE80000, 8'h00},
    {1'b1, 4'h4, 32'hFFE80000, 8'h00},
    {1'b0, 4'h4, 32'hFF680000, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic f, input logic [3:0] n);
    @(negedge clk);
    frameN = f;
    ladIn  = n;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 4'hF);
      chk(ladOe == 1'b0, "R8 idle", {31'b0, ladOe}, 0);
    end
  endtask

  // Runs one bus cycle. abortAt/stopAt of 0 mean never.
  task automatic doTxn(input logic [44:0] v, input logic [3:0] startNib, input int abortAt,
                       input logic [3:0] abortNib, input int stopAt);
    logic        resp, wr, typeGood, upperGood;
    logic [3:0]  ct;
    logic [31:0] a;
    logic [7:0]  d, ed;
    string       tag;
    int          last;
    ct = v[43:40]; a = v[39:8]; d = v[7:0]; wr = ct[1];
    typeGood  = (ct[3:2] == 2'b01) && (ct[1] || !ct[0]);
    upperGood = &a[31:23];
    resp = typeGood && upperGood && (a[21:18] == ~idStrap) && (startNib == 4'h0);
    if (startNib != 4'h0) tag = "R1";
    else if (!typeGood) tag = "R2";
    else if (!upperGood) tag = "R3";
    else if (!resp) tag = "R4";
    else tag = wr ? "R6" : "R5";
    ed = a[7:0] ^ {a[22], 7'h2B};
    last = wr ? 17 : 19;
    for (int cyc = 1; cyc <= last; cyc++) begin
      logic       f, expOe;
      logic [3:0] n, expNib;
      if (cyc == stopAt) return;
      if (cyc == abortAt) begin
        step(1'b0, abortNib);
        chk(ladOe == 1'b0, "R8 abort", {31'b0, ladOe}, 0);
        return;
      end
      f = 1'b1; n = 4'hF;
      if (cyc == 1) begin f = 1'b0; n = startNib; end
      else if (cyc == 2) n = ct;
      else if (cyc <= 10) n = a[4*(10-cyc) +: 4];
      else if (wr && cyc == 11) n = d[3:0];
      else if (wr && cyc == 12) n = d[7:4];
      step(f, n);
      expOe = 1'b0; expNib = 4'hF;
      if (resp && !wr) begin
        case (cyc)
          13, 14: begin expOe = 1'b1; expNib = 4'h5; end
          15: begin expOe = 1'b1; expNib = 4'h0; end
          16: begin expOe = 1'b1; expNib = ed[3:0]; end
          17: begin expOe = 1'b1; expNib = ed[7:4]; end
          18: begin expOe = 1'b1; expNib = 4'hF; end
          default: ;
        endcase
      end else if (resp && wr) begin
        case (cyc)
          15: begin expOe = 1'b1; expNib = 4'h0; end
          16: begin expOe = 1'b1; expNib = 4'hF; end
          default: ;
        endcase
      end
      chk(ladOe == expOe, tag, {31'b0, ladOe}, {31'b0, expOe});
      if (expOe) chk(ladOut == expNib, tag, {28'b0, ladOut}, {28'b0, expNib});
      if (!wr && cyc == 11) begin
        chk(beRd == resp, "R5 read strobe", {31'b0, beRd}, {31'b0, resp});
        if (resp) begin
          chk(beAddr == a[17:0], "R3 addr", {14'b0, beAddr}, {14'b0, a[17:0]});
          chk(beArray == a[22], "R3 array", {31'b0, beArray}, {31'b0, a[22]});
        end
      end
      if (wr && cyc == 13) begin
        chk(beWr == resp, "R7 write strobe", {31'b0, beWr}, {31'b0, resp});
        if (resp) begin
          chk(beWdata == d, "R6 data", {24'b0, beWdata}, {24'b0, d});
          chk(beAddr == a[17:0], "R3 addr", {14'b0, beAddr}, {14'b0, a[17:0]});
          chk(beArray == a[22], "R3 array", {31'b0, beArray}, {31'b0, a[22]});
        end
      end
      if (!resp) chk(!beRd && !beWr, tag, {30'b0, beRd, beWr}, 0);
    end
  endtask

  initial begin
    int expRd, expWr, snap;
    rstN = 1'b0; initN = 1'b1; frameN = 1'b1; ladIn = 4'hF; idStrap = 4'b0101;
    repeat (3) @(negedge clk);
    #1;
    chk(!ladOe && !beRd && !beWr, "R9 reset", {29'b0, ladOe, beRd, beWr}, 0);
    rstN = 1'b1;
    idle(2);

    // Table of vectors.
    expRd = 0; expWr = 0;
    for (int i = 0; i < 11; i++) begin
      doTxn(VEC[i], 4'h0, 0, 4'hF, 0);
      if (VEC[i][44] && VEC[i][41]) expWr++;
      else if (VEC[i][44]) expRd++;
      idle(1);
    end
    chk(rdCnt == expRd, "R10 read count", rdCnt, expRd);
    chk(wrCnt == expWr, "R10 write count", wrCnt, expWr);

    // R4: another strap value.
    idStrap = 4'b0000;
    doTxn({1'b1, 4'h4, 32'hFFFC0123, 8'h00}, 4'h0, 0, 4'hF, 0);
    doTxn({1'b0, 4'h4, 32'hFFE80123, 8'h00}, 4'h0, 0, 4'hF, 0);
    idStrap = 4'b0101;
    idle(1);

    // R1: framed nibble that is not a start.
    doTxn({1'b1, 4'h4, 32'hFFE80040, 8'h00}, 4'hA, 0, 4'hF, 0);
    idle(1);

    // R8: abort in wait sync, bus released at once, then idle.
    doTxn({1'b1, 4'h4, 32'hFFE80055, 8'h00}, 4'h0, 13, 4'hF, 0);
    idle(3);

    // R8: restart from a framed start nibble mid address.
    doTxn({1'b1, 4'h4, 32'hFFE80066, 8'h00}, 4'h0, 9, 4'h0, 0);
    doTxn({1'b1, 4'h4, 32'hFFE80077, 8'h00}, 4'h0, 0, 4'hF, 0);
    idle(1);

    // R7: abort on the high data nibble cancels the write.
    snap = wrCnt;
    doTxn({1'b1, 4'h6, 32'hFFE80100, 8'h5A}, 4'h0, 12, 4'hF, 0);
    idle(4);
    chk(wrCnt == snap, "R7 abort before commit", wrCnt, snap);

    // R7: abort in the host turnaround after commit keeps the write.
    snap = wrCnt;
    doTxn({1'b1, 4'h6, 32'hFFE80200, 8'hC3}, 4'h0, 14, 4'hF, 0);
    idle(3);
    chk(wrCnt == snap + 1, "R7 abort after commit", wrCnt, snap + 1);

    // R9: processor reset in the middle of a read.
    doTxn({1'b1, 4'h4, 32'hFFE80300, 8'h00}, 4'h0, 0, 4'hF, 14);
    @(negedge clk); initN = 1'b0; #1;
    chk(!ladOe, "R9 initN releases bus", {31'b0, ladOe}, 0);
    @(negedge clk); #1;
    chk(!ladOe && !beRd && !beWr, "R9 held idle", {29'b0, ladOe, beRd, beWr}, 0);
    initN = 1'b1;
    idle(2);
    doTxn({1'b1, 4'h4, 32'hFFE80301, 8'h00}, 4'h0, 0, 4'hF, 0);
    idle(1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule